// File: doc/BRIEF.md
# Serial Link Port Status and Control Register Block

This block holds the software-visible registers of one serial link port. It sits on a simple 32-bit read/write bus with word addresses and three mapped words. The first word holds the link time-out interval. The second word is the port error-and-status word. The third word is the port control word. Reads are combinational: `bus_rdata` reflects `bus_addr` in the same cycle. A write takes effect at the clock edge where `bus_we` is high.

The recovery state machines, lane training and the transceivers live elsewhere. They reach this block only as level inputs (port initialised and the four stopped states) and as single-cycle event pulses. The block turns the pulses into sticky bits that software clears by writing 1. It derives a port-OK flag from the initialised input, a saturating count of received status symbols and the four stopped states. It also drives the port's enable outputs, a buffer flush and a one-cycle reinitialise request. Control and status pins are plain levels or pulses. None of them carries a handshake.

Word map: word 0 is the time-out word, word 1 is the status word, word 2 is the control word. All other word addresses are unmapped.

Top module: `sport_csr`

## Requirements
- R1: Word 0 holds a 24-bit time-out value in bits 31:8. The value resets to 0xFFFFFF and drives `link_timeout`. Bits 7:0 always read 0, and a write stores only `bus_wdata[31:8]`.
- R2: Status word bits 2 (port error), 3 (input error seen), 5 (output error seen) and 7 (output retry seen) are sticky. They are set by `ev_port_err`, `ev_in_err`, `ev_out_err` and `ev_out_rty` respectively. Writing 1 to a bit position of word 1 clears that bit. An event arriving in the same cycle as a clear of the same bit leaves the bit set.
- R3: Port-OK (status bit 1) is 1 only when all of the following hold: `port_init` is 1, at least 7 `stat_sym` pulses have been counted since `port_init` last rose, and all four stop inputs are 0. Status bits 4, 6, 8 and 9 show the inputs `in_err_stop`, `out_err_stop`, `out_rty_stop` and `in_rty_stop`.
- R4: Status bit 0 (uninitialised) is always the inverse of port-OK, so the status word reads 0x001 out of reset when all inputs are 0.
- R5: The status-symbol count saturates at 7, so further pulses keep port-OK at 1. The count returns to zero whenever `port_init` is 0, so after `port_init` returns, 7 new pulses are needed.
- R6: When control bit 4 (port disable) changes from 1 to 0, `reinit` is 1 for exactly one cycle, which is the cycle after the write edge. No other write produces it.
- R7: While port disable is 1, `buf_flush` is 1 and `tx_req_out` is 0. Otherwise `tx_req_out` follows `tx_req_in`.
- R8: The control word has four read/write bits. Bit 4 is port disable and resets to 0. Bit 5 is transmit enable and resets to 1. Bit 6 is receive enable and resets to 1. Bit 7 is error-check disable and resets to 0. These bits drive `port_dis`, `tx_en`, `rx_en` and `err_chk_dis`.
- R9: Control bit 0 (port type) reads 1. Bits 2:1 hold the lane-count code set by `LANES`: 00 for one lane, 10 for two lanes, 01 for four lanes. These bits and all other control bits are read-only, so with `LANES`=1 the control word resets to 0x61.
- R10: `port_error` always equals status bit 2.
- R11: Unmapped word addresses read 0, and writes to them change nothing. Writes to read-only status bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| port_init | input | 1 | Link is initialised |
| stat_sym | input | 1 | Pulse: a status symbol was received |
| in_rty_stop | input | 1 | Input retry machine is stopped |
| in_err_stop | input | 1 | Input error machine is stopped |
| out_rty_stop | input | 1 | Output retry machine is stopped |
| out_err_stop | input | 1 | Output error machine is stopped |
| ev_out_rty | input | 1 | Pulse: output retry encountered |
| ev_out_err | input | 1 | Pulse: output error encountered |
| ev_in_err | input | 1 | Pulse: input error encountered |
| ev_port_err | input | 1 | Pulse: unrecoverable port error |
| tx_req_in | input | 1 | Transmit request from the upper layer |
| tx_req_out | output | 1 | Transmit request passed on to the link |
| link_timeout | output | TMO_W | Link time-out interval |
| port_dis | output | 1 | Port disable |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| err_chk_dis | output | 1 | Error checking disable |
| reinit | output | 1 | One-cycle force-reinitialise request |
| buf_flush | output | 1 | Keep the transmit and receive buffers flushed |
| port_error | output | 1 | Mirror of the sticky port-error bit |

## Verification
Two functions can act in the same cycle: a hardware event setting a sticky bit and a software write-1 clearing it. The bench sweeps every combination of 4-bit pre-set state, 4-bit event vector and 4-bit clear mask. In each case the event pulses and the clearing write are driven in the same cycle. It then reads the status word and compares it against (pre AND NOT clear) OR event, so a set always wins over a clear. A second coincidence is a status-symbol pulse in the cycle where `port_init` falls. This is judged by requiring port-OK to stay low until seven fresh pulses arrive.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int DATA_W  = 32;
  localparam int WA_TMO  = 0;
  localparam int WA_STAT = 1;
  localparam int WA_CTRL = 2;

  // status word bit positions
  localparam int SB_UNINIT  = 0;
  localparam int SB_OK      = 1;
  localparam int SB_PERR    = 2;
  localparam int SB_IERR    = 3;
  localparam int SB_ISTOP_E = 4;
  localparam int SB_OERR    = 5;
  localparam int SB_OSTOP_E = 6;
  localparam int SB_ORTY    = 7;
  localparam int SB_OSTOP_R = 8;
  localparam int SB_ISTOP_R = 9;

  // control word bit positions
  localparam int CB_DIS  = 4;
  localparam int CB_TXEN = 5;
  localparam int CB_RXEN = 6;
  localparam int CB_ECD  = 7;

  function automatic logic [1:0] lane_code(input int lanes);
    case (lanes)
      2:       lane_code = 2'b10;
      4:       lane_code = 2'b01;
      default: lane_code = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/sport_sticky.sv
module sport_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]); // R2
  end
endmodule

// File: rtl/sport_link_ok.sv
module sport_link_ok #(
  parameter int SYM_NEED = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_init,
  input  logic       stat_sym,
  input  logic [3:0] stops,
  output logic       port_ok
);
  localparam int CNT_W = $clog2(SYM_NEED + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SYM_NEED);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !port_init)              cnt <= '0;
    else if (stat_sym && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  assign port_ok = port_init && (cnt == CNT_MAX) && (stops == 4'b0);

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (port_init && cnt == CNT_MAX) |=> (!port_init || cnt == CNT_MAX)); // R5
  AST_OK_LOST_ON_UNINIT: assert property (@(posedge clk) disable iff (!rst_n)
    !port_init |=> !port_ok); // R3
endmodule

// File: rtl/sport_ctl.sv
module sport_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_dis,
  input  logic w_txen,
  input  logic w_rxen,
  input  logic w_ecd,
  output logic port_dis,
  output logic tx_en,
  output logic rx_en,
  output logic err_chk_dis,
  output logic reinit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_dis    <= 1'b0;
      tx_en       <= 1'b1;
      rx_en       <= 1'b1;
      err_chk_dis <= 1'b0;
      reinit      <= 1'b0;
    end else begin
      reinit <= wr && port_dis && !w_dis;
      if (wr) begin
        port_dis    <= w_dis;
        tx_en       <= w_txen;
        rx_en       <= w_rxen;
        err_chk_dis <= w_ecd;
      end
    end
  end

  AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit); // R6
  AST_REINIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> (!port_dis && $past(port_dis))); // R6
endmodule

// File: rtl/sport_csr.sv
module sport_csr
  import sport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TMO_W    = 24,
  parameter int LANES    = 1,
  parameter int SYM_NEED = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              port_init,
  input  logic              stat_sym,
  input  logic              in_rty_stop,
  input  logic              in_err_stop,
  input  logic              out_rty_stop,
  input  logic              out_err_stop,
  input  logic              ev_out_rty,
  input  logic              ev_out_err,
  input  logic              ev_in_err,
  input  logic              ev_port_err,
  input  logic              tx_req_in,
  output logic              tx_req_out,
  output logic [TMO_W-1:0]  link_timeout,
  output logic              port_dis,
  output logic              tx_en,
  output logic              rx_en,
  output logic              err_chk_dis,
  output logic              reinit,
  output logic              buf_flush,
  output logic              port_error
);
  localparam int LOW_W = DATA_W - TMO_W;
  localparam logic [1:0] LCODE = lane_code(LANES);

  logic sel_tmo, sel_stat, sel_ctrl;
  assign sel_tmo  = bus_addr == ADDR_W'(WA_TMO);
  assign sel_stat = bus_addr == ADDR_W'(WA_STAT);
  assign sel_ctrl = bus_addr == ADDR_W'(WA_CTRL);

  // time-out word
  always_ff @(posedge clk) begin
    if (!rst_n)                 link_timeout <= '1;
    else if (bus_we && sel_tmo) link_timeout <= bus_wdata[DATA_W-1:LOW_W];
  end

  // sticky events: [0] port err, [1] in err, [2] out err, [3] out retry
  logic [3:0] st_set, st_clr, st_q;
  assign st_set = {ev_out_rty, ev_out_err, ev_in_err, ev_port_err};
  assign st_clr = (bus_we && sel_stat) ?
                  {bus_wdata[SB_ORTY], bus_wdata[SB_OERR], bus_wdata[SB_IERR], bus_wdata[SB_PERR]} :
                  4'b0;

  sport_sticky #(.N(4)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(st_q)
  );

  logic port_ok;
  sport_link_ok #(.SYM_NEED(SYM_NEED)) u_link_ok (
    .clk(clk), .rst_n(rst_n), .port_init(port_init), .stat_sym(stat_sym),
    .stops({in_rty_stop, in_err_stop, out_rty_stop, out_err_stop}),
    .port_ok(port_ok)
  );

  sport_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(bus_we && sel_ctrl),
    .w_dis(bus_wdata[CB_DIS]), .w_txen(bus_wdata[CB_TXEN]),
    .w_rxen(bus_wdata[CB_RXEN]), .w_ecd(bus_wdata[CB_ECD]),
    .port_dis(port_dis), .tx_en(tx_en), .rx_en(rx_en),
    .err_chk_dis(err_chk_dis), .reinit(reinit)
  );

  assign buf_flush  = port_dis;
  assign tx_req_out = tx_req_in && !port_dis;
  assign port_error = st_q[0];

  logic [DATA_W-1:0] stat_word, ctrl_word;
  always_comb begin
    stat_word             = '0;
    stat_word[SB_UNINIT]  = !port_ok;
    stat_word[SB_OK]      = port_ok;
    stat_word[SB_PERR]    = st_q[0];
    stat_word[SB_IERR]    = st_q[1];
    stat_word[SB_ISTOP_E] = in_err_stop;
    stat_word[SB_OERR]    = st_q[2];
    stat_word[SB_OSTOP_E] = out_err_stop;
    stat_word[SB_ORTY]    = st_q[3];
    stat_word[SB_OSTOP_R] = out_rty_stop;
    stat_word[SB_ISTOP_R] = in_rty_stop;
    ctrl_word             = '0;
    ctrl_word[0]          = 1'b1;
    ctrl_word[2:1]        = LCODE;
    ctrl_word[CB_DIS]     = port_dis;
    ctrl_word[CB_TXEN]    = tx_en;
    ctrl_word[CB_RXEN]    = rx_en;
    ctrl_word[CB_ECD]     = err_chk_dis;
  end

  always_comb begin
    if (sel_tmo)       bus_rdata = {link_timeout, {LOW_W{1'b0}}};
    else if (sel_stat) bus_rdata = stat_word;
    else if (sel_ctrl) bus_rdata = ctrl_word;
    else               bus_rdata = '0;
  end

  AST_TMO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tmo |-> bus_rdata[LOW_W-1:0] == '0); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_tmo && !sel_stat && !sel_ctrl) |-> bus_rdata == '0); // R11
  AST_DROP_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    buf_flush |-> !tx_req_out); // R7
  AST_PORT_ERR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_port_err |=> port_error); // R10
endmodule

// File: tb/sport_csr_bench.sv
`timescale 1ns/1ps
module sport_csr_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic port_init = 0, stat_sym = 0;
  logic in_rty_stop = 0, in_err_stop = 0, out_rty_stop = 0, out_err_stop = 0;
  logic ev_out_rty = 0, ev_out_err = 0, ev_in_err = 0, ev_port_err = 0;
  logic tx_req_in = 0, tx_req_out;
  logic [23:0] link_timeout;
  logic port_dis, tx_en, rx_en, err_chk_dis, reinit, buf_flush, port_error;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sport_csr u_sport_csr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = 4'(a); bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a); #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] spread(input logic [3:0] v);
    spread = 0;
    spread[2] = v[0]; spread[3] = v[1]; spread[5] = v[2]; spread[7] = v[3];
  endfunction

  task automatic pulse_ev(input logic [3:0] v);
    @(negedge clk); {ev_out_rty, ev_out_err, ev_in_err, ev_port_err} = v;
    @(negedge clk); {ev_out_rty, ev_out_err, ev_in_err, ev_port_err} = 0;
  endtask

  task automatic pulse_sym(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); stat_sym = 1;
      @(negedge clk); stat_sym = 0;
    end
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd(0, d); chk("R1 reset", d, 32'hFFFFFF00);
    chk("R1 output", {8'h0, link_timeout}, 32'h00FFFFFF);
    rd(1, d); chk("R4 reset", d, 32'h001);
    rd(2, d); chk("R8 R9 reset", d, 32'h61);
    chk("R8 outputs", {28'h0, port_dis, tx_en, rx_en, err_chk_dis}, 32'h6);

    // R1 walking pattern
    for (int b = 0; b < 32; b++) begin
      wr(0, 32'h1 << b);
      rd(0, d); chk("R1 walk", d, (32'h1 << b) & 32'hFFFFFF00);
    end
    wr(0, 32'h12345678);
    chk("R1 output", {8'h0, link_timeout}, 32'h00123456);

    // R11 unmapped
    for (int a = 3; a < 16; a++) begin
      wr(a, 32'hFFFFFFFF);
      rd(a, d); chk("R11 unmapped", d, 0);
    end
    rd(0, d); chk("R11 no side effect", d, 32'h12345600);
    rd(2, d); chk("R11 no side effect ctrl", d, 32'h61);
    wr(1, 32'hFFFFFFFF);
    rd(1, d); chk("R11 RO status", d, 32'h001);

    // R2 and R10 exhaustive sweep, set versus clear in one cycle
    for (int p = 0; p < 16; p++)
      for (int e = 0; e < 16; e++)
        for (int c = 0; c < 16; c++) begin
          wr(1, 32'hAC);
          pulse_ev(4'(p));
          @(negedge clk);
          {ev_out_rty, ev_out_err, ev_in_err, ev_port_err} = 4'(e);
          bus_addr = 1; bus_we = 1; bus_wdata = spread(4'(c));
          @(negedge clk);
          {ev_out_rty, ev_out_err, ev_in_err, ev_port_err} = 0; bus_we = 0;
          rd(1, d);
          chk("R2 sticky", d, spread((4'(p) & ~4'(c)) | 4'(e)) | 32'h1);
          chk("R10 mirror", {31'h0, port_error}, {31'h0, d[2]});
        end
    wr(1, 32'hAC);

    // R3 R5 count sweep
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); port_init = 0;
      @(negedge clk); port_init = 1;
      pulse_sym(n);
      rd(1, d);
      chk("R3 R5 count", d[1:0], (n >= 7) ? 32'h2 : 32'h1);
    end
    // R5 init drop coinciding with a pulse
    @(negedge clk); port_init = 0; stat_sym = 1;
    @(negedge clk); stat_sym = 0; port_init = 1;
    pulse_sym(6);
    rd(1, d); chk("R5 restart", d[1:0], 32'h1);
    pulse_sym(1);
    rd(1, d); chk("R5 restart done", d[1:0], 32'h2);

    // R3 R4 stop sweep
    for (int s = 0; s < 16; s++) begin
      {in_rty_stop, in_err_stop, out_rty_stop, out_err_stop} = 4'(s);
      rd(1, d);
      chk("R3 stop bits", d & 32'h350,
          (32'(s[0]) << 6) | (32'(s[1]) << 8) | (32'(s[2]) << 4) | (32'(s[3]) << 9));
      chk("R4 inverse", d[1:0], (s == 0) ? 32'h2 : 32'h1);
    end
    {in_rty_stop, in_err_stop, out_rty_stop, out_err_stop} = 0;

    // R8 R9 control write
    wr(2, 32'hFFFFFFFF);
    rd(2, d); chk("R8 R9 write all", d, 32'hF1);
    chk("R8 outputs", {28'h0, port_dis, tx_en, rx_en, err_chk_dis}, 32'hF);
    // R7 disabled
    tx_req_in = 1; #1;
    chk("R7 flush", {31'h0, buf_flush}, 1);
    chk("R7 drop", {31'h0, tx_req_out}, 0);
    // R6 1 to 0
    wr(2, 32'h61);
    chk("R6 pulse", {31'h0, reinit}, 1);
    chk("R7 pass", {31'h0, tx_req_out}, 1);
    @(negedge clk);
    chk("R6 single", {31'h0, reinit}, 0);
    wr(2, 32'h61);
    chk("R6 no pulse", {31'h0, reinit}, 0);
    wr(2, 32'h10);
    chk("R6 rise no pulse", {31'h0, reinit}, 0);
    rd(2, d); chk("R8 partial", d, 32'h11);
    wr(2, 32'h00);
    chk("R6 pulse again", {31'h0, reinit}, 1);
    rd(2, d); chk("R8 cleared", d, 32'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule